// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller that serves several banks of pins through one 32-bit register port. For every bank it keeps a set of per-pin control words: which pins are inputs, whether each pin is claimed for the GPIO function, the value to drive, and how each pin's interrupt is detected and reported. It drives an output enable and an output value for each pin and samples the pad inputs through a synchronizer. Each bank raises one interrupt line.

Interrupt detection covers a level (high or low) or a single edge (rising or falling) per pin. A detection sets a sticky status bit. Software acknowledges a pin by writing zero to its status bit. Triggering on both edges is done in software, which flips the polarity after each event. The register word for one kind of control sits at a fixed offset per kind. The copies for the different banks follow each other in steps of four bytes. The byte offset is `kind_offset + 4 * bank`, and the kinds are spaced 16 bytes apart.

Top module: `gpio_multibank_ctrl`

## Requirements
- R1: After reset every direction word reads 0x3FFFFFFF (all pins inputs). Polarity, type, enable, status, function-enable and data-out words read zero. All `pad_oe` bits are low and all `bank_irq` bits are low.
- R2: Register kinds sit at byte offsets 0x00 direction, 0x20 polarity, 0x30 type, 0x40 interrupt enable, 0x50 status, 0x60 function enable, 0x70 data-in and 0x80 data-out. Each kind's copy for bank b is at that offset plus 4*b. Bits 31:30 read as zero and are dropped on write. Data-in ignores writes. Any other offset, and any bank index of 3, reads zero and ignores writes.
- R3: `pad_oe` for a pin is high only when that pin's function-enable bit is 1 and its direction bit is 0. `pad_out` follows the pin's data-out bit whatever the direction.
- R4: Data-in returns the pad level through a two-flop synchronizer. A pad change made before clock edge E1 reads back after edge E2. This holds for inputs and outputs alike.
- R5: Type bit 0 selects level detection and 1 selects edge detection. Polarity bit 1 selects high level or rising edge, and 0 selects low level or falling edge. A detection sets the pin's status bit, which stays set until cleared. A pad edge made before clock edge E1 sets status at E3. The opposite edge sets nothing.
- R6: A write to a status word clears the bits written 0 and leaves the bits written 1 unchanged. Clearing wins over a detection in the same cycle. A level that is still active sets the bit again one cycle after the clear.
- R7: `bank_irq[b]` is high exactly when some pin of bank b has direction, status and interrupt-enable all set.
- R8: A pin whose function-enable bit is 0 never sets its status bit, whatever its pad does.
- R9: A write to one bank's word changes no other bank's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 90 | Pad levels, bank b at bits [30b+29:30b] |
| pad_oe | output | 90 | Output enable per pin |
| pad_out | output | 90 | Output value per pin |
| bank_irq | output | 3 | Interrupt line per bank |

## Verification
A corrupted status bit shows on `bank_irq` one cycle after the bad edge, provided the pin is an enabled input. Otherwise it shows only through a status read, so the bench reads status words directly and also gates the interrupt through direction and enable.

A stale or mis-staged synchronizer shifts the cycle in which status and data-in change. For that reason the bench samples at the exact edge count: status must still be clear after two edges and set after the third.

A decode slip between banks or kinds shows as a value appearing in a neighbour's word. The bench therefore reads the untouched banks after each targeted write.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

    // Register kind, taken from byte address bits [7:4]
    typedef enum logic [3:0] {
        KIND_DIR  = 4'h0,
        KIND_POL  = 4'h2,
        KIND_TYP  = 4'h3,
        KIND_IEN  = 4'h4,
        KIND_STS  = 4'h5,
        KIND_FEN  = 4'h6,
        KIND_DIN  = 4'h7,
        KIND_DOUT = 4'h8
    } reg_kind_e;

    localparam int KIND_LSB = 4;
    localparam int BANK_LSB = 2;
    localparam int BANK_FW  = 2;

endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
    parameter int WIDTH = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta = raw_i;
        sy_d.cur  = sy_q.meta;
        sy_d.prev = sy_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign cur_o  = sy_q.cur;
    assign prev_o = sy_q.prev;

    // R4: the synchronized level is the first stage one cycle later
    assert_sync_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sy_q.cur == $past(sy_q.meta)));

endmodule

// File: rtl/gpio_mb_detect.sv
module gpio_mb_detect #(
    parameter int WIDTH = 30
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] pol_high_i,
    input  logic [WIDTH-1:0] armed_i,
    output logic [WIDTH-1:0] hit_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise_p, fall_p, lvl_p, edg_p;
        always_comb begin
            rise_p   = cur_i[p] & ~prev_i[p];
            fall_p   = ~cur_i[p] & prev_i[p];
            lvl_p    = pol_high_i[p] ? cur_i[p] : ~cur_i[p];
            edg_p    = pol_high_i[p] ? rise_p : fall_p;
            hit_o[p] = armed_i[p] & (edge_mode_i[p] ? edg_p : lvl_p);
        end
    end

endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int PINS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_kind_e       wr_kind,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pad_raw,
    output logic [PINS-1:0] dir_o,
    output logic [PINS-1:0] pol_o,
    output logic [PINS-1:0] typ_o,
    output logic [PINS-1:0] ien_o,
    output logic [PINS-1:0] sts_o,
    output logic [PINS-1:0] fen_o,
    output logic [PINS-1:0] dout_o,
    output logic [PINS-1:0] din_o,
    output logic [PINS-1:0] oe_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] typ;
        logic [PINS-1:0] ien;
        logic [PINS-1:0] sts;
        logic [PINS-1:0] fen;
        logic [PINS-1:0] dout;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [PINS-1:0] cur, prev, hit, clr_mask, pending;

    gpio_mb_sync #(.WIDTH(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_raw),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gpio_mb_detect #(.WIDTH(PINS)) u_detect (
        .cur_i       (cur),
        .prev_i      (prev),
        .edge_mode_i (st_q.typ),
        .pol_high_i  (st_q.pol),
        .armed_i     (st_q.fen),
        .hit_o       (hit)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (wr_en) begin
            case (wr_kind)
                KIND_DIR:  st_d.dir  = wdata;
                KIND_POL:  st_d.pol  = wdata;
                KIND_TYP:  st_d.typ  = wdata;
                KIND_IEN:  st_d.ien  = wdata;
                KIND_STS:  clr_mask  = ~wdata;
                KIND_FEN:  st_d.fen  = wdata;
                KIND_DOUT: st_d.dout = wdata;
                default:   ;
            endcase
        end
        st_d.sts = (st_q.sts | hit) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pending = st_q.dir & st_q.sts & st_q.ien;
        irq_o   = |pending;
        oe_o    = st_q.fen & ~st_q.dir;
    end

    assign dir_o  = st_q.dir;
    assign pol_o  = st_q.pol;
    assign typ_o  = st_q.typ;
    assign ien_o  = st_q.ien;
    assign sts_o  = st_q.sts;
    assign fen_o  = st_q.fen;
    assign dout_o = st_q.dout;
    assign din_o  = cur;

    // R6: bits written zero are clear on the following cycle
    assert_sts_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_STS) |=> ((st_q.sts & ~$past(wdata)) == '0));

    // R5: without a status write no set bit is lost
    assert_sts_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_kind == KIND_STS) |=> ((st_q.sts & $past(st_q.sts)) == $past(st_q.sts)));

    // R8: a newly set status bit belongs to a pin that was function-enabled
    assert_fen_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sts & ~$past(st_q.sts) & ~$past(st_q.fen)) == '0));

    // R7: the interrupt line needs an enabled input pin
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((st_q.ien & st_q.dir) != '0));

endmodule

// File: rtl/gpio_multibank_ctrl.sv
module gpio_multibank_ctrl
    import gpio_mb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PINS      = 30,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_en,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [NUM_BANKS*PINS-1:0] pad_in,
    output logic [NUM_BANKS*PINS-1:0] pad_oe,
    output logic [NUM_BANKS*PINS-1:0] pad_out,
    output logic [NUM_BANKS-1:0]      bank_irq
);
    localparam int TOTAL = NUM_BANKS * PINS;

    reg_kind_e          kind;
    logic [BANK_FW-1:0] bidx;
    logic               addr_hi_ok;
    logic               bank_ok;
    logic [PINS-1:0]    rd_val;

    logic [PINS-1:0] dir_a  [NUM_BANKS];
    logic [PINS-1:0] pol_a  [NUM_BANKS];
    logic [PINS-1:0] typ_a  [NUM_BANKS];
    logic [PINS-1:0] ien_a  [NUM_BANKS];
    logic [PINS-1:0] sts_a  [NUM_BANKS];
    logic [PINS-1:0] fen_a  [NUM_BANKS];
    logic [PINS-1:0] dout_a [NUM_BANKS];
    logic [PINS-1:0] din_a  [NUM_BANKS];

    always_comb begin
        kind       = reg_kind_e'(reg_addr[KIND_LSB +: 4]);
        bidx       = reg_addr[BANK_LSB +: BANK_FW];
        addr_hi_ok = ((reg_addr >> 8) == '0);
        bank_ok    = addr_hi_ok && (32'(bidx) < NUM_BANKS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_wr;
        logic [PINS-1:0] oe_b;
        assign sel_wr = reg_en && reg_wr && addr_hi_ok && (32'(bidx) == b);

        gpio_mb_bank #(.PINS(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr),
            .wr_kind (kind),
            .wdata   (reg_wdata[PINS-1:0]),
            .pad_raw (pad_in[b*PINS +: PINS]),
            .dir_o   (dir_a[b]),
            .pol_o   (pol_a[b]),
            .typ_o   (typ_a[b]),
            .ien_o   (ien_a[b]),
            .sts_o   (sts_a[b]),
            .fen_o   (fen_a[b]),
            .dout_o  (dout_a[b]),
            .din_o   (din_a[b]),
            .oe_o    (oe_b),
            .irq_o   (bank_irq[b])
        );

        assign pad_oe[b*PINS +: PINS]  = oe_b;
        assign pad_out[b*PINS +: PINS] = dout_a[b];
    end

    always_comb begin
        rd_val = '0;
        if (bank_ok) begin
            case (kind)
                KIND_DIR:  rd_val = dir_a[bidx];
                KIND_POL:  rd_val = pol_a[bidx];
                KIND_TYP:  rd_val = typ_a[bidx];
                KIND_IEN:  rd_val = ien_a[bidx];
                KIND_STS:  rd_val = sts_a[bidx];
                KIND_FEN:  rd_val = fen_a[bidx];
                KIND_DIN:  rd_val = din_a[bidx];
                KIND_DOUT: rd_val = dout_a[bidx];
                default:   rd_val = '0;
            endcase
        end
        reg_rdata              = '0;
        reg_rdata[PINS-1:0]    = rd_val;
    end

    // R3: a driven pad always belongs to a pin whose output value is reachable on pad_out
    assert_oe_needs_fen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[0]) |-> (fen_a[0][0] && !dir_a[0][0]));

    // R1: no pad is driven in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && bank_irq == '0));

    initial begin
        assert_params_R2: assert (NUM_BANKS <= 4 && PINS <= DATA_W && ADDR_W >= 8 && TOTAL > 0);
    end

endmodule

// File: tb/gpio_multibank_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_multibank_ctrl_tb;
    localparam int NB = 3;
    localparam int NP = 30;
    localparam logic [31:0] LOW30 = 32'h3FFF_FFFF;

    localparam logic [7:0] O_DIR = 8'h00, O_POL = 8'h20, O_TYP = 8'h30,
        O_IEN = 8'h40, O_STS = 8'h50, O_FEN = 8'h60, O_DIN = 8'h70, O_DOUT = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_en = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB*NP-1:0] pad_in = '0;
    logic [NB*NP-1:0] pad_oe, pad_out;
    logic [NB-1:0] bank_irq;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    gpio_multibank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .bank_irq(bank_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] off, input int bank, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1;
        reg_addr = off + 8'(4 * bank); reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input int bank, output logic [31:0] d);
        reg_addr = off + 8'(4 * bank);
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(O_DIR, b, v);  chk("R1 dir", v, LOW30);
            rd(O_POL, b, v);  chk("R1 pol", v, 0);
            rd(O_STS, b, v);  chk("R1 sts", v, 0);
            rd(O_FEN, b, v);  chk("R1 fen", v, 0);
            rd(O_DOUT, b, v); chk("R1 dout", v, 0);
        end
        chk("R1 oe", 32'(pad_oe == '0), 1);
        chk("R1 irq", 32'(bank_irq), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(O_POL, 1, 32'hC000_0005);
        rd(O_POL, 1, v); chk("R2 pol upper bits dropped", v, 32'h5);
        wr(O_TYP, 1, 32'h0000_0A00);
        rd(O_TYP, 1, v); chk("R2 type", v, 32'hA00);
        wr(O_IEN, 1, 32'h1234_5678);
        rd(O_IEN, 1, v); chk("R2 enable", v, 32'h1234_5678);
        rd(O_IEN, 0, v); chk("R9 bank0 untouched", v, 0);
        rd(O_IEN, 2, v); chk("R9 bank2 untouched", v, 0);
        rd(O_POL, 2, v); chk("R9 bank2 pol", v, 0);
        wr(O_IEN, 1, 0);
        wr(O_TYP, 1, 0);
        wr(O_POL, 1, 0);
        wr(8'h10, 0, 32'hFFFF_FFFF);
        rd(8'h10, 0, v); chk("R2 unmapped offset", v, 0);
        wr(O_DOUT, 3, 32'hFFFF_FFFF);
        rd(O_DOUT, 3, v); chk("R2 bank3 reads zero", v, 0);
        rd(O_DOUT, 2, v); chk("R2 bank3 write ignored", v, 0);
        wr(O_DIN, 1, 32'hFFFF_FFFF);
        rd(O_DIN, 1, v); chk("R2 data-in write ignored", v, 0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(O_DIR, 1, LOW30 & ~32'(1 << 5));
        wr(O_DOUT, 1, 32'(1 << 5));
        chk("R3 oe low while fen=0", 32'(pad_oe[NP+5]), 0);
        chk("R3 out follows dout", 32'(pad_out[NP+5]), 1);
        wr(O_FEN, 1, 32'(1 << 5));
        chk("R3 oe high fen=1 dir=0", 32'(pad_oe[NP+5]), 1);
        chk("R3 other pins not driven", 32'(pad_oe[NP+4]), 0);
        pad_in[NP+5] = 1'b1;
        step(1);
        rd(O_DIN, 1, v); chk("R4 din after one edge", v & 32'(1 << 5), 0);
        step(1);
        rd(O_DIN, 1, v); chk("R4 din on output pin", v & 32'(1 << 5), 32'(1 << 5));
        wr(O_FEN, 1, 0);
        wr(O_DIR, 1, LOW30);
        wr(O_DOUT, 1, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        logic [31:0] m = 32'(1 << 3);
        wr(O_TYP, 0, m);
        wr(O_POL, 0, m);
        wr(O_IEN, 0, m);
        wr(O_FEN, 0, m);
        rd(O_STS, 0, v); chk("R5 no spurious status", v, 0);
        pad_in[3] = 1'b1;
        step(2);
        rd(O_STS, 0, v); chk("R5 status clear after two edges", v, 0);
        step(1);
        rd(O_STS, 0, v); chk("R5 rising edge sets status", v, m);
        chk("R7 irq raised", 32'(bank_irq), 1);
        wr(O_DIR, 0, LOW30 & ~m);
        chk("R7 irq gated by direction", 32'(bank_irq), 0);
        wr(O_DIR, 0, LOW30);
        chk("R7 irq back with direction", 32'(bank_irq), 1);
        wr(O_IEN, 0, 0);
        chk("R7 irq gated by enable", 32'(bank_irq), 0);
        wr(O_IEN, 0, m);
        wr(O_STS, 0, ~m);
        rd(O_STS, 0, v); chk("R6 edge status cleared", v, 0);
        chk("R7 irq drops after clear", 32'(bank_irq), 0);
        pad_in[3] = 1'b0;
        step(4);
        rd(O_STS, 0, v); chk("R5 falling edge ignored for rising", v, 0);
        wr(O_POL, 0, 0);
        pad_in[3] = 1'b1;
        step(4);
        rd(O_STS, 0, v); chk("R5 rising ignored for falling", v, 0);
        pad_in[3] = 1'b0;
        step(3);
        rd(O_STS, 0, v); chk("R5 falling edge sets status", v, m);
        wr(O_STS, 0, 32'hFFFF_FFFF);
        rd(O_STS, 0, v); chk("R6 writing one keeps status", v, m);
        wr(O_STS, 0, 0);
        wr(O_FEN, 0, 0);
        wr(O_IEN, 0, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        logic [31:0] m = 32'(1 << 29);
        wr(O_FEN, 2, m);
        rd(O_STS, 2, v); chk("R5 level not yet latched", v, 0);
        step(1);
        rd(O_STS, 2, v); chk("R5 low level sets status", v, m);
        wr(O_STS, 2, 32'hFFFF_FFFF & ~m);
        rd(O_STS, 2, v); chk("R6 clear wins same cycle", v, 0);
        step(1);
        rd(O_STS, 2, v); chk("R6 active level sets again", v, m);
        pad_in[2*NP+29] = 1'b1;
        step(3);
        wr(O_STS, 2, 0);
        step(2);
        rd(O_STS, 2, v); chk("R6 inactive level stays clear", v, 0);
        rd(O_STS, 0, v); chk("R9 bank0 status untouched", v, 0);
        wr(O_FEN, 2, 0);
    endtask

    task automatic t_fen_gate();
        logic [31:0] v;
        wr(O_TYP, 1, 32'h1);
        wr(O_POL, 1, 32'h1);
        wr(O_STS, 1, 0);
        pad_in[NP] = 1'b1;
        step(4);
        pad_in[NP] = 1'b0;
        step(4);
        rd(O_STS, 1, v); chk("R8 disabled pin never sets status", v, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regmap();
        t_output();
        t_edge();
        t_level();
        t_fen_gate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule